// File: doc/BRIEF.md
# Single-Point Genome Crossover Unit

This block is the recombination step of a hardware genetic algorithm. Two parent genomes of N bits and an unsigned split index enter. Two child genomes leave. Each child keeps the upper part of one parent and takes the lower part of the other parent. The lower part runs from bit 0 up to and including the bit that the split index names.

The split index is first expanded into a thermometer mask, in which bit k is set when k is not above the split. Each child bit then picks between the two parents through that mask. No slice has a width that depends on the data, so the logic maps to plain gates with no storage. The output register is optional: a parameter selects either a purely combinational path or one register stage after the select.

Top module: `genome_xover`

## Requirements
- R1: For every split value s below N-1, child_a bits N-1..s+1 equal parent_a, and child_a bits s..0 equal parent_b.
- R2: For every split value s below N-1, child_b bits N-1..s+1 equal parent_b, and child_b bits s..0 equal parent_a.
- R3: The split index is read as an unsigned number. Any value of N-1 or more swaps the whole word, so child_a equals parent_b and child_b equals parent_a.
- R4: With N=64, split 7, parent_a all zeros and parent_b all ones, child_a is 64'h0000_0000_0000_00FF and child_b is its bitwise complement.
- R5: With split 0, only bit 0 is exchanged between the parents. All other bits pass straight through.
- R6: At every bit position, the pair of child bits is the pair of parent bits, either kept or swapped. So child_a^child_b equals parent_a^parent_b, and child_a&child_b equals parent_a&parent_b.
- R7: With REG_OUT=0 the children follow the inputs with no clock. With REG_OUT=1 they show the result for the inputs present at the previous rising clock edge.
- R8: With REG_OUT=1, both children read zero while rst_n (active low, asynchronous) is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| parent_a | input | N | First parent genome |
| parent_b | input | N | Second parent genome |
| split | input | R | Unsigned crossover index; the last bit taken from the other parent |
| child_a | output | N | Upper bits from parent_a, lower bits from parent_b |
| child_b | output | N | Upper bits from parent_b, lower bits from parent_a |

## Verification
On every cycle, the assertions check four things:
- the mask is a thermometer code that holds split+1 ones, or is all ones when the split is N-1 or more;
- each bit pair of the children is a permutation of the parent pair;
- bit 0 always comes from the other parent;
- a full swap happens at the top split values.

Only the bench scenarios can show that the exchange boundary sits at the exact split position for every index. They also show the split-7 pattern, the one-cycle latency and the reset value of the registered variant. They do this by comparing both children against a shift-built reference, over every split value and several parent patterns.

// File: rtl/genome_xover.sv
module genome_xover #(
  parameter int N       = 64,
  parameter int R       = 6,
  parameter bit REG_OUT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] parent_a,
  input  logic [N-1:0] parent_b,
  input  logic [R-1:0] split,
  output logic [N-1:0] child_a,
  output logic [N-1:0] child_b
);

  logic [N-1:0] low_mask;
  logic [N-1:0] mix_a;
  logic [N-1:0] mix_b;

  for (genvar k = 0; k < N; k++) begin : g_therm
    assign low_mask[k] = (32'(split) >= k);
  end

  assign mix_a = (parent_a & ~low_mask) | (parent_b & low_mask);
  assign mix_b = (parent_b & ~low_mask) | (parent_a & low_mask);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        child_a <= '0;
        child_b <= '0;
      end else begin
        child_a <= mix_a;
        child_b <= mix_b;
      end
    end
  end else begin : g_comb
    assign child_a = mix_a;
    assign child_b = mix_b;
  end

  // R1
  therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_mask[0] && ((low_mask & (low_mask + 1'b1)) == '0));

  // R3
  therm_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(split) >= N - 1) ? (low_mask == '1)
                          : ($countones(low_mask) == 32'(split) + 1));

  // R6
  bit_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mix_a ^ mix_b) == (parent_a ^ parent_b)) &&
    ((mix_a & mix_b) == (parent_a & parent_b)));

  // R5
  low_bit_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_a[0] == parent_b[0]) && (mix_b[0] == parent_a[0]));

  // R3
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(split) >= N - 1) |-> (mix_a == parent_b && mix_b == parent_a));

endmodule

// File: tb/sim_genome_xover.sv
module sim_genome_xover;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] pa, pb;
  logic [5:0]  sp;
  logic [63:0] ca, cb;
  logic [15:0] ra, rb;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  genome_xover #(.N(64), .R(6), .REG_OUT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .parent_a(pa), .parent_b(pb), .split(sp),
    .child_a(ca), .child_b(cb));

  genome_xover #(.N(16), .R(4), .REG_OUT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .parent_a(pa[15:0]), .parent_b(pb[15:0]),
    .split(sp[3:0]), .child_a(ra), .child_b(rb));

  function automatic logic [63:0] lowm(int s, int n);
    logic [63:0] w;
    w = (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
    if (s >= n - 1) return w;
    return ((64'd1 << (s + 1)) - 64'd1) & w;
  endfunction

  function automatic logic [63:0] mix(logic [63:0] hi, logic [63:0] lo, int s, int n);
    logic [63:0] m;
    m = lowm(s, n);
    return (hi & ~m) | (lo & m);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(logic [63:0] a, logic [63:0] b, int s);
    logic [63:0] ea, eb, fa, fb;
    int s16;
    @(negedge clk);
    pa = a; pb = b; sp = 6'(s);
    s16 = s % 16;
    ea = mix(a, b, s, 64);
    eb = mix(b, a, s, 64);
    #2;
    check(s == 63 ? "R3 child_a" : "R1 child_a", ca, ea);
    check(s == 63 ? "R3 child_b" : "R2 child_b", cb, eb);
    if (s == 0) check("R5 child_a", ca, (a & ~64'd1) | (b & 64'd1));
    check("R6 xor", ca ^ cb, a ^ b);
    check("R6 and", ca & cb, a & b);
    fa = mix({48'd0, a[15:0]}, {48'd0, b[15:0]}, s16, 16);
    fb = mix({48'd0, b[15:0]}, {48'd0, a[15:0]}, s16, 16);
    @(negedge clk);
    check("R7 registered child_a", {48'd0, ra}, fa);
    check("R7 registered child_b", {48'd0, rb}, fb);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    pa = 64'hDEAD_BEEF_0123_4567; pb = 64'h0F0F_F0F0_A5A5_5A5A; sp = 6'd5;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 reset child_a", {48'd0, ra}, 64'd0);
    check("R8 reset child_b", {48'd0, rb}, 64'd0);
    check("R7 comb during reset", ca, mix(pa, pb, 5, 64));
    rst_n = 1'b1;

    run_vec(64'd0, '1, 7);
    check("R4 child_a", ca, 64'h0000_0000_0000_00FF);
    check("R4 child_b", cb, 64'hFFFF_FFFF_FFFF_FF00);

    for (int s = 0; s < 64; s++) begin
      run_vec(64'd0, '1, s);
      run_vec('1, 64'd0, s);
      run_vec(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, s);
      run_vec({$urandom, $urandom}, {$urandom, $urandom}, s);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule